// File: doc/BRIEF.md
# Synchronous serial shift unit

The unit moves one 8-bit byte per transfer through a single shift register. It sends one bit on a serial data pin on every clock period and takes in one bit from a serial data pin on every clock period. As clock master it makes its own serial clock from the system clock, at one of eight division rates. As clock slave it follows a serial clock from outside, which it first brings into the system clock domain. The caller sets the clock polarity, the clock phase and the bit order. The caller loads a byte and asserts start. A one-cycle done pulse marks the end of the transfer, and the received byte is then held in a read register.

Two data pins, A and B, serve the shift register, and the routing depends on the master and shared-line controls together. In separate-line mode the master sends on A and receives on B, while the slave sends on B and receives on A. In shared-line mode one pin carries both directions: pin A for a master, pin B for a slave. A pin drives only while transmit is enabled. Receive enable decides whether the read register takes the new byte.

Top module: `sync_shift_unit`

## Requirements
- R1: After reset, busy_o = 0, done_o = 0, rx_data_o = 0, and no data pin drives while tx_en_i = 0.
- R2: With master_i = 1, sck_oe_o = 1 and sck_o rests at cpol_i while idle. During a transfer sck_o makes exactly 16 transitions, and consecutive transitions are 2 << rate_i system clocks apart (division by 4, 8, ... 512 for rate_i = 0..7).
- R3: With master_i = 0, sck_oe_o = 0, and the unit shifts on edges of sck_i after a 2-flop synchronizer. A full transfer completes on 16 external transitions whose spacing is at least 4 system clocks.
- R4: The leading edge is the transition away from the cpol_i level. With cpha_i = 0, the first bit is on the output before the first edge, input is captured on leading edges and the output changes on trailing edges. With cpha_i = 1, the output changes on leading edges and input is captured on trailing edges.
- R5: msb_first_i = 0 sends and receives bit 0 first. msb_first_i = 1 sends and receives bit 7 first. The received byte keeps the same bit weights as the sender's byte.
- R6: With bidir_i = 0, a master sends on pa_o and samples pa_i never, receiving on pb_i. A slave sends on pb_o and receives on pa_i.
- R7: With bidir_i = 1, a master sends and receives on pin A and a slave on pin B. The other pin's output enable stays 0, and at most one of pa_oe_o and pb_oe_o is ever 1.
- R8: The output enable of the sending pin equals tx_en_i. With rx_en_i = 0, a completed transfer leaves rx_data_o unchanged.
- R9: done_o is 1 for exactly one cycle per transfer, in the cycle busy_o falls. rx_data_o changes only in that cycle.
- R10: start_i is ignored while busy_o = 1. The running transfer keeps its loaded byte, and a change of tx_data_i during the transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = clock master, 0 = clock slave |
| bidir_i | input | 1 | 1 = shared single data line |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Capture edge select |
| msb_first_i | input | 1 | 1 = bit 7 first, 0 = bit 0 first |
| rate_i | input | 3 | Master clock divider select |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable |
| start_i | input | 1 | Load tx_data_i and begin a transfer |
| tx_data_i | input | 8 | Byte to send |
| rx_data_o | output | 8 | Last received byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| sck_i | input | 1 | External serial clock (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock drive enable |
| pa_i | input | 1 | Data pin A input |
| pa_o | output | 1 | Data pin A output |
| pa_oe_o | output | 1 | Data pin A drive enable |
| pb_i | input | 1 | Data pin B input |
| pb_o | output | 1 | Data pin B output |
| pb_oe_o | output | 1 | Data pin B drive enable |

## Verification
A wrong edge count or divider value shows at sck_o within one half period, as a transition spacing off from 2 << rate_i. It also shows at the end of the transfer, as a missing or early done_o. A shift that runs the wrong way, or that captures on the wrong edge, leaves a bit-permuted or bit-shifted byte on rx_data_o and in the bench peer's captured byte, visible the cycle done_o rises. A routing fault shows at once as a drive enable on the wrong pin, or as the complemented byte, because the bench drives the unused data pin with inverted data.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef struct packed {
    logic out_a;
    logic in_a;
  } route_t;

  function automatic route_t pick_route(logic master, logic bidir);
    route_t r;
    r.out_a = master;
    r.in_a  = bidir ? master : ~master;
    return r;
  endfunction
endpackage

// File: rtl/ssu_clkgen.sv
module ssu_clkgen #(
  parameter  int N_RATES   = 8,
  parameter  int BASE_DIV  = 4,
  localparam int RATE_W    = $clog2(N_RATES),
  localparam int HALF_BASE = BASE_DIV / 2,
  localparam int CNT_W     = $clog2(HALF_BASE) + N_RATES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              cpol_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              run_i,
  input  logic              load_i,
  input  logic              sck_i,
  output logic              edge_o,
  output logic              lead_o,
  output logic              sck_o
);
  logic [CNT_W-1:0] cnt_q, half;
  logic             lvl_q, m_tick;
  logic [2:0]       sync_q;

  assign half   = CNT_W'(HALF_BASE) << rate_i;
  assign m_tick = master_i && run_i && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (master_i && run_i) begin
      cnt_q <= m_tick ? '0 : cnt_q + CNT_W'(1);
      if (m_tick) lvl_q <= ~lvl_q;
    end
  end

  // external clock: two sync flops plus one history flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], sck_i};
  end

  assign edge_o = master_i ? m_tick : (sync_q[1] ^ sync_q[2]);
  assign lead_o = master_i ? ~lvl_q : (sync_q[1] ^ cpol_i);
  assign sck_o  = cpol_i ^ lvl_q;
endmodule

// File: rtl/ssu_core.sv
module ssu_core #(
  parameter  int W    = 8,
  localparam int EC_W = $clog2(2 * W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cpha_i,
  input  logic         msb_first_i,
  input  logic         rx_en_i,
  input  logic         start_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         edge_i,
  input  logic         lead_i,
  input  logic         sin_i,
  output logic         busy_o,
  output logic         load_o,
  output logic         done_o,
  output logic         sout_o,
  output logic [W-1:0] rx_data_o
);
  logic [W-1:0]    sr_q, sr_shift, sr_next, rx_q;
  logic [EC_W-1:0] ec_q;
  logic            busy_q, done_q, out_q;
  logic            act, cap, lnc, last;

  assign act  = edge_i & busy_q;
  assign cap  = act & (lead_i ^ cpha_i);
  assign lnc  = act & ~(lead_i ^ cpha_i);
  assign last = act && (ec_q == EC_W'(2 * W - 1));

  assign sr_shift = msb_first_i ? {sr_q[W-2:0], sin_i} : {sin_i, sr_q[W-1:1]};
  assign sr_next  = cap ? sr_shift : sr_q;
  assign load_o   = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      rx_q   <= '0;
      ec_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        sr_q   <= tx_data_i;
        out_q  <= msb_first_i ? tx_data_i[W-1] : tx_data_i[0];
        ec_q   <= '0;
        busy_q <= 1'b1;
      end else if (act) begin
        sr_q <= sr_next;
        ec_q <= ec_q + EC_W'(1);
        if (lnc) out_q <= msb_first_i ? sr_q[W-1] : sr_q[0];
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (rx_en_i) rx_q <= sr_next;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign sout_o    = out_q;
  assign rx_data_o = rx_q;
endmodule

// File: rtl/ssu_pinmux.sv
module ssu_pinmux
  import ssu_pkg::*;
(
  input  logic master_i,
  input  logic bidir_i,
  input  logic tx_en_i,
  input  logic sout_i,
  input  logic pa_i,
  input  logic pb_i,
  output logic pa_o,
  output logic pa_oe_o,
  output logic pb_o,
  output logic pb_oe_o,
  output logic sin_o
);
  route_t rt;

  assign rt      = pick_route(master_i, bidir_i);
  assign pa_o    = sout_i;
  assign pb_o    = sout_i;
  assign pa_oe_o = tx_en_i & rt.out_a;
  assign pb_oe_o = tx_en_i & ~rt.out_a;
  assign sin_o   = rt.in_a ? pa_i : pb_i;
endmodule

// File: rtl/sync_shift_unit.sv
module sync_shift_unit #(
  parameter  int W        = 8,
  parameter  int N_RATES  = 8,
  parameter  int BASE_DIV = 4,
  localparam int RATE_W   = $clog2(N_RATES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              bidir_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              msb_first_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              start_i,
  input  logic [W-1:0]      tx_data_i,
  output logic [W-1:0]      rx_data_o,
  output logic              busy_o,
  output logic              done_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              pa_i,
  output logic              pa_o,
  output logic              pa_oe_o,
  input  logic              pb_i,
  output logic              pb_o,
  output logic              pb_oe_o
);
  logic edge_w, lead_w, load_w, sin_w, sout_w, busy_w;

  ssu_clkgen #(.N_RATES(N_RATES), .BASE_DIV(BASE_DIV)) i_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master_i),
    .cpol_i   (cpol_i),
    .rate_i   (rate_i),
    .run_i    (busy_w),
    .load_i   (load_w),
    .sck_i    (sck_i),
    .edge_o   (edge_w),
    .lead_o   (lead_w),
    .sck_o    (sck_o)
  );

  ssu_core #(.W(W)) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpha_i      (cpha_i),
    .msb_first_i (msb_first_i),
    .rx_en_i     (rx_en_i),
    .start_i     (start_i),
    .tx_data_i   (tx_data_i),
    .edge_i      (edge_w),
    .lead_i      (lead_w),
    .sin_i       (sin_w),
    .busy_o      (busy_w),
    .load_o      (load_w),
    .done_o      (done_o),
    .sout_o      (sout_w),
    .rx_data_o   (rx_data_o)
  );

  ssu_pinmux i_pinmux (
    .master_i (master_i),
    .bidir_i  (bidir_i),
    .tx_en_i  (tx_en_i),
    .sout_i   (sout_w),
    .pa_i     (pa_i),
    .pb_i     (pb_i),
    .pa_o     (pa_o),
    .pa_oe_o  (pa_oe_o),
    .pb_o     (pb_o),
    .pb_oe_o  (pb_oe_o),
    .sin_o    (sin_w)
  );

  assign busy_o   = busy_w;
  assign sck_oe_o = master_i;
endmodule

// File: rtl/sync_shift_unit_chk.sv
module sync_shift_unit_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         master_i,
  input logic         cpol_i,
  input logic         tx_en_i,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] rx_data_o,
  input logic         sck_o,
  input logic         sck_oe_o,
  input logic         pa_oe_o,
  input logic         pb_oe_o
);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r9_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rx_data_o));
  a_r3_slave_no_sck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !sck_oe_o);
  a_r2_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !busy_o) |-> (sck_o == cpol_i));
  a_r8_tx_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> (!pa_oe_o && !pb_oe_o));
  a_r7_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pa_oe_o && pb_oe_o));
  a_r6_master_pin_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && tx_en_i) |-> pa_oe_o);
  a_r6_slave_pin_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && tx_en_i) |-> pb_oe_o);
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind sync_shift_unit sync_shift_unit_chk #(.W(W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .master_i  (master_i),
  .cpol_i    (cpol_i),
  .tx_en_i   (tx_en_i),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rx_data_o (rx_data_o),
  .sck_o     (sck_o),
  .sck_oe_o  (sck_oe_o),
  .pa_oe_o   (pa_oe_o),
  .pb_oe_o   (pb_oe_o)
);

// File: tb/test_sync_shift_unit.sv
module test_sync_shift_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master, bidir, cpol, cpha, msbf, tx_en, rx_en, start, sck_in, pa_in, pb_in;
  logic [2:0] rate;
  logic [7:0] tx_data, rx_data;
  logic       busy, done, sck_out, sck_oe, pa_out, pa_oe, pb_out, pb_oe;

  always #10 clk = ~clk;

  sync_shift_unit i_sync_shift_unit (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .bidir_i(bidir),
    .cpol_i(cpol), .cpha_i(cpha), .msb_first_i(msbf), .rate_i(rate),
    .tx_en_i(tx_en), .rx_en_i(rx_en), .start_i(start), .tx_data_i(tx_data),
    .rx_data_o(rx_data), .busy_o(busy), .done_o(done), .sck_i(sck_in),
    .sck_o(sck_out), .sck_oe_o(sck_oe), .pa_i(pa_in), .pa_o(pa_out),
    .pa_oe_o(pa_oe), .pb_i(pb_in), .pb_o(pb_out), .pb_oe_o(pb_oe)
  );

  int n_chk = 0, n_fail = 0, done_cnt = 0, cyc = 0;
  int ncap, nlaunch;
  logic [7:0] cap, peer_q, exp_rx = 8'h00;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bpos(input int i, input bit msb);
    return msb ? 7 - i : i;
  endfunction

  // input pin per R6/R7; the unused pin gets the complement
  task automatic set_in(input bit b);
    bit in_a;
    in_a = bidir ? master : !master;
    if (in_a) begin pa_in = b; pb_in = ~b; end
    else      begin pb_in = b; pa_in = ~b; end
  endtask

  task automatic edge_act(input int e);
    bit lead, o;
    int idx;
    lead = (e % 2) == 1;
    o = master ? pa_out : pb_out;
    if (lead ^ cpha) begin
      if (ncap < 8) cap[bpos(ncap, msbf)] = o;
      ncap++;
    end else begin
      idx = cpha ? nlaunch : nlaunch + 1;
      if (idx < 8) set_in(peer_q[bpos(idx, msbf)]);
      nlaunch++;
    end
  endtask

  task automatic xfer(input bit m, input bit bd, input bit pol, input bit ph, input bit msb,
                      input logic [2:0] rt, input bit txe, input bit rxe,
                      input logic [7:0] tx, input logic [7:0] peer, input bit poke);
    int trans, bad_iv, oe_bad, c, last;
    bit prev, poked;
    @(negedge clk);
    master = m; bidir = bd; cpol = pol; cpha = ph; msbf = msb; rate = rt;
    tx_en = txe; rx_en = rxe; tx_data = tx; sck_in = pol; peer_q = peer;
    ncap = 0; nlaunch = 0; cap = 8'h00; trans = 0; bad_iv = 0; oe_bad = 0; poked = 0;
    set_in(peer[bpos(0, msb)]);
    repeat (6) @(negedge clk);
    done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (m) begin
      prev = sck_out; c = 0; last = 0;
      while ((trans < 16 || busy) && c < 20000) begin
        if ((pa_oe != txe) || pb_oe || !sck_oe) oe_bad++;
        if (sck_out != prev) begin
          trans++; prev = sck_out;
          if (trans > 1 && (c - last) != (2 << rt)) bad_iv++;
          last = c;
          edge_act(trans);
        end
        if (poke && trans == 5 && !poked) begin
          tx_data = ~tx; start = 1'b1; poked = 1;
        end else start = 1'b0;
        @(negedge clk); c++;
      end
      chk(trans == 16, "R2 transition count", trans, 16);
      chk(bad_iv == 0, "R2 half period", bad_iv, 0);
      chk(sck_out == pol, "R2 idle level", sck_out, pol);
    end else begin
      repeat (4) @(negedge clk);
      for (int e = 1; e <= 16; e++) begin
        sck_in = ~sck_in;
        edge_act(e);
        repeat (8) begin
          if ((pb_oe != txe) || pa_oe || sck_oe) oe_bad++;
          @(negedge clk);
        end
      end
      repeat (8) @(negedge clk);
    end
    chk(!busy, "R3/R9 busy cleared", busy, 0);
    chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    chk(oe_bad == 0, "R6/R7/R8 drive enables", oe_bad, 0);
    if (txe) chk(cap == tx, "R4/R5/R6 sent byte", cap, tx);
    if (rxe) exp_rx = peer;
    chk(rx_data == exp_rx, "R4/R5/R8 received byte", rx_data, exp_rx);
  endtask

  initial begin
    master = 0; bidir = 0; cpol = 0; cpha = 0; msbf = 0; rate = 0;
    tx_en = 0; rx_en = 0; start = 0; tx_data = 0; sck_in = 0; pa_in = 0; pb_in = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 reset flags", {busy, done}, 0);
    chk(rx_data == 8'h00, "R1 reset rx", rx_data, 0);
    chk(!pa_oe && !pb_oe && !sck_oe, "R1 no drive", {pa_oe, pb_oe, sck_oe}, 0);
    rst_n = 1'b1;
    // master, separate lines: every mode/order, each at its own rate
    for (int k = 0; k < 8; k++)
      xfer(1, 0, k[0], k[1], k[2], k[2:0], 1, 1, 8'hA5 ^ 8'(k * 37), 8'h3C ^ 8'(k * 53), 0);
    // single-bit patterns probe bit order (R5)
    xfer(1, 0, 0, 0, 1, 3'd0, 1, 1, 8'h01, 8'h80, 0);
    xfer(1, 0, 1, 1, 0, 3'd1, 1, 1, 8'h80, 8'h01, 0);
    // R10 start during transfer ignored
    xfer(1, 0, 0, 1, 0, 3'd2, 1, 1, 8'h96, 8'h5A, 1);
    // R7 master shared line: send only, then receive only
    xfer(1, 1, 0, 0, 1, 3'd1, 1, 0, 8'hC3, 8'hFF, 0);
    xfer(1, 1, 1, 0, 0, 3'd0, 0, 1, 8'h00, 8'h6D, 0);
    // R3 slave, separate lines, all modes and orders
    for (int k = 0; k < 8; k++)
      xfer(0, 0, k[0], k[1], k[2], 3'd0, 1, 1, 8'h17 + 8'(k * 29), 8'hE2 - 8'(k * 41), 0);
    // R7 slave shared line, R8 receive disabled keeps rx
    xfer(0, 1, 0, 1, 1, 3'd0, 1, 0, 8'h4B, 8'h00, 0);
    xfer(0, 1, 1, 1, 0, 3'd0, 0, 1, 8'h00, 8'hB4, 0);
    // R8 both disabled: nothing driven, rx unchanged
    xfer(0, 0, 0, 0, 0, 3'd0, 0, 0, 8'hFF, 8'h11, 0);
    finish_run();
  end
endmodule